// File: doc/BRIEF.md
# Serial-Bus Memory Target Engine

This block is the bus-facing front end of a byte-addressed nonvolatile memory that sits on a two-wire serial bus. It oversamples the raw clock and data lines on the system clock and recognises START and STOP conditions. It decodes the control byte, which carries a fixed device code, three chip-select bits and a direction bit. It collects a two-byte word address and then either streams bytes out of the memory or hands incoming bytes to a separate page-buffer block. The block never drives the data line high. Its only drive is a pull-down enable for an open-drain pad.

A write hands each data byte to the page buffer through a one-cycle strobe that carries the byte and its target address. A STOP that closes a write with at least one data byte raises a commit strobe. While the page buffer reports an internal write cycle in progress, the block refuses every control byte, so a master can poll for completion. Reads come from a simple asynchronous read port. The read address is the internal pointer, and the returned data must settle within one half period of the serial clock.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset the pull-down enable and both write strobes are low. A START (data falling while the clock is high) begins a new control byte from any state. A STOP (data rising while the clock is high) returns the block to idle.
- R2: In the control byte, bits 7:4 must equal 1010 and bits 3:1 must equal the strap inputs, with bit 3 compared to strap bit 2. Bit 0 set means read. A matching byte is acknowledged by holding the data line low while the clock is high during the ninth clock.
- R3: A control byte with the wrong code or the wrong select bits is not acknowledged. The block then leaves the line released until the next START and acknowledges none of the bytes that follow.
- R4: While the busy input is high, even a matching control byte is not acknowledged.
- R5: After a write control byte, two address bytes follow, high byte first, and each is acknowledged. Bits 7:5 of the high byte are ignored, and the other 13 bits load the pointer.
- R6: Every data byte of a write is acknowledged and produces a one-cycle write strobe with the pointer value and the byte. The pointer's low 5 bits then advance and wrap within the 32-byte page, while bits 12:5 hold.
- R7: A STOP after at least one data byte produces a one-cycle commit strobe. A STOP or repeated START with no data byte stores nothing. A repeated START after the address bytes keeps the loaded pointer.
- R8: A read sends the byte at the pointer, most significant bit first. The pull-down enable changes only while the clock is low.
- R9: The pointer advances by one after every byte read, so a following current-address read returns the next location.
- R10: An acknowledge from the master after a read byte makes the block send the next byte, and the pointer rolls over from 0x1FFF to 0x0000.
- R11: A missing acknowledge after a read byte makes the block release the line and stay off it until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line, as seen on the pad |
| sda_oe_o | output | 1 | Pull-down enable for the open-drain data pad |
| strap_sel_i | input | 3 | Chip-select strap levels |
| busy_i | input | 1 | Page buffer is in its internal write cycle |
| rd_addr_o | output | 13 | Read address, equal to the internal pointer |
| rd_data_i | input | 8 | Memory byte at rd_addr_o |
| wr_valid_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | 13 | Target address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| wr_end_o | output | 1 | One-cycle commit strobe at a STOP that closes a write |

## Verification
The bench targets three pointer cases. The first is a page write that starts two bytes before a page edge: a pointer that carried into bit 5 would put the third byte on the next page instead of at the page start. The second is a sequential read across 0x1FFF: it would show a wrong third byte if the read increment were page-limited or left unwrapped. The third is a current-address read after a random read, which exposes a pointer that fails to advance.

For the line itself, the bench releases SDA after a master NACK and keeps clocking, so a design that still drives the line shows up as a low bit. It also checks wrong code, wrong select and the busy input, where a design that acknowledges would pull the line low during the ninth clock. A repeated START placed after the address bytes catches a design that commits a write with no data.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_AHI,
      ST_ALO,
      ST_WDAT,
      ST_READ
   } tgt_state_e;

   localparam logic [3:0] DEV_CODE_DEFAULT = 4'b1010;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   initial begin
      assert (STAGES >= 2) else $error("i2c_line_sync: STAGES must be at least 2");
   end

   logic scl_ff [STAGES];
   logic sda_ff [STAGES];
   logic scl_prev, sda_prev;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff[g] <= 1'b1;
               sda_ff[g] <= 1'b1;
            end else begin
               scl_ff[g] <= scl_i;
               sda_ff[g] <= sda_i;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff[g] <= 1'b1;
               sda_ff[g] <= 1'b1;
            end else begin
               scl_ff[g] <= scl_ff[g-1];
               sda_ff[g] <= sda_ff[g-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_ff[STAGES-1];
         sda_prev <= sda_ff[STAGES-1];
      end
   end

   assign scl_lvl   = scl_ff[STAGES-1];
   assign sda_lvl   = sda_ff[STAGES-1];
   assign scl_rise  = scl_lvl & ~scl_prev;
   assign scl_fall  = ~scl_lvl & scl_prev;
   assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_addr_ptr.sv
module i2c_addr_ptr #(
   parameter int ADDR_W = 13,
   parameter int PAGE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step_seq,
   input  logic              step_page,
   output logic [ADDR_W-1:0] ptr
);

   initial begin
      assert (PAGE_W >= 0 && PAGE_W < ADDR_W)
         else $error("i2c_addr_ptr: PAGE_W must be below ADDR_W");
   end

   logic [ADDR_W-1:0] seq_next;
   logic [ADDR_W-1:0] page_next;

   assign seq_next = ptr + ADDR_W'(1);

   if (PAGE_W > 0) begin : g_paged
      logic [PAGE_W-1:0] low_next;
      assign low_next  = ptr[PAGE_W-1:0] + PAGE_W'(1);
      assign page_next = {ptr[ADDR_W-1:PAGE_W], low_next};

      // Page writes never leave the current page
      assert_page_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (step_page && !load) |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));
   end else begin : g_flat
      assign page_next = seq_next;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ptr <= '0;
      else if (load)       ptr <= load_val;
      else if (step_seq)   ptr <= seq_next;
      else if (step_page)  ptr <= page_next;
   end

   assert_ptr_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (step_seq && !load && (&ptr)) |=> (ptr == '0));

endmodule

// File: rtl/i2c_mem_ctrl.sv
module i2c_mem_ctrl
   import i2c_mem_pkg::*;
#(
   parameter int          ADDR_W   = 13,
   parameter int          SEL_W    = 3,
   parameter logic [3:0]  DEV_CODE = DEV_CODE_DEFAULT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_lvl,
   input  logic              sda_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [SEL_W-1:0]  strap_sel,
   input  logic              busy,
   input  logic [7:0]        rd_data,
   input  logic [ADDR_W-1:0] ptr,
   output logic              ptr_load,
   output logic [ADDR_W-1:0] ptr_load_val,
   output logic              step_seq,
   output logic              step_page,
   output logic              sda_oe,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              wr_end
);

   localparam int HI_W   = ADDR_W - 8;
   localparam int CODE_W = 8 - SEL_W - 1;

   initial begin
      assert (CODE_W == 4) else $error("i2c_mem_ctrl: select field must leave a 4-bit code");
      assert (HI_W >= 1 && HI_W <= 8) else $error("i2c_mem_ctrl: ADDR_W must be 9..16");
   end

   tgt_state_e       state;
   logic [3:0]       bit_cnt;
   logic [7:0]       rx_sh;
   logic [7:0]       tx_sh;
   logic [HI_W-1:0]  hi_q;
   logic             rw_q;
   logic             mack_q;
   logic             data_seen;

   logic             busy_evt;
   logic             byte_done;
   logic             ack_end;
   logic             ctrl_ok;

   assign busy_evt  = (state != ST_IDLE) && !start_det && !stop_det;
   assign byte_done = busy_evt && scl_fall && (bit_cnt == 4'd8);
   assign ack_end   = busy_evt && scl_fall && (bit_cnt == 4'd9);
   assign ctrl_ok   = (rx_sh[7:SEL_W+1] == DEV_CODE) &&
                      (rx_sh[SEL_W:1] == strap_sel) && !busy;

   assign ptr_load     = byte_done && (state == ST_ALO);
   assign ptr_load_val = {hi_q, rx_sh};
   assign step_page    = byte_done && (state == ST_WDAT);
   assign step_seq     = byte_done && (state == ST_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bit_cnt   <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         hi_q      <= '0;
         rw_q      <= 1'b0;
         mack_q    <= 1'b0;
         data_seen <= 1'b0;
         sda_oe    <= 1'b0;
         wr_valid  <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         wr_end    <= 1'b0;
      end else begin
         wr_valid <= 1'b0;
         wr_end   <= 1'b0;
         if (start_det) begin
            state     <= ST_CTRL;
            bit_cnt   <= '0;
            sda_oe    <= 1'b0;
            data_seen <= 1'b0;
         end else if (stop_det) begin
            if (state == ST_WDAT && data_seen) wr_end <= 1'b1;
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            sda_oe    <= 1'b0;
            data_seen <= 1'b0;
         end else if (state != ST_IDLE) begin
            if (scl_rise) begin
               if (bit_cnt < 4'd8 && state != ST_READ) rx_sh <= {rx_sh[6:0], sda_lvl};
               if (bit_cnt == 4'd8 && state == ST_READ) mack_q <= ~sda_lvl;
               if (bit_cnt < 4'd9) bit_cnt <= bit_cnt + 4'd1;
            end
            if (byte_done) begin
               unique case (state)
                  ST_CTRL: begin
                     if (ctrl_ok) begin
                        sda_oe <= 1'b1;
                        rw_q   <= rx_sh[0];
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_IDLE;
                     end
                  end
                  ST_AHI: begin
                     sda_oe <= 1'b1;
                     hi_q   <= rx_sh[HI_W-1:0];
                  end
                  ST_ALO: sda_oe <= 1'b1;
                  ST_WDAT: begin
                     sda_oe    <= 1'b1;
                     wr_valid  <= 1'b1;
                     wr_addr   <= ptr;
                     wr_data   <= rx_sh;
                     data_seen <= 1'b1;
                  end
                  ST_READ: sda_oe <= 1'b0;
                  default: sda_oe <= 1'b0;
               endcase
            end else if (ack_end) begin
               bit_cnt <= '0;
               unique case (state)
                  ST_CTRL: begin
                     if (rw_q) begin
                        state  <= ST_READ;
                        tx_sh  <= rd_data;
                        sda_oe <= ~rd_data[7];
                     end else begin
                        state  <= ST_AHI;
                        sda_oe <= 1'b0;
                     end
                  end
                  ST_AHI: begin
                     state  <= ST_ALO;
                     sda_oe <= 1'b0;
                  end
                  ST_ALO: begin
                     state  <= ST_WDAT;
                     sda_oe <= 1'b0;
                  end
                  ST_WDAT: sda_oe <= 1'b0;
                  ST_READ: begin
                     if (mack_q) begin
                        tx_sh  <= rd_data;
                        sda_oe <= ~rd_data[7];
                     end else begin
                        state  <= ST_IDLE;
                        sda_oe <= 1'b0;
                     end
                  end
                  default: sda_oe <= 1'b0;
               endcase
            end else if (busy_evt && scl_fall && state == ST_READ &&
                         bit_cnt != 4'd0) begin
               sda_oe <= ~tx_sh[3'd7 - bit_cnt[2:0]];
            end
         end
      end
   end

   assert_sda_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> (!$past(scl_lvl) || $past(start_det) || $past(stop_det)));

   assert_busy_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && state == ST_CTRL && busy) |=> !sda_oe);

   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

   assert_wr_acked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> sda_oe);

   assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE && !sda_oe));

   assert_nack_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_end && state == ST_READ && !mack_q) |=> (state == ST_IDLE && !sda_oe));

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
   import i2c_mem_pkg::*;
#(
   parameter int          ADDR_W      = 13,
   parameter int          PAGE_W      = 5,
   parameter int          SEL_W       = 3,
   parameter int          SYNC_STAGES = 2,
   parameter logic [3:0]  DEV_CODE    = DEV_CODE_DEFAULT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic [SEL_W-1:0]  strap_sel_i,
   input  logic              busy_i,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [7:0]        rd_data_i,
   output logic              wr_valid_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [7:0]        wr_data_o,
   output logic              wr_end_o
);

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic ptr_load, step_seq, step_page;
   logic [ADDR_W-1:0] ptr, ptr_load_val;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_lvl   (scl_lvl),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ptr_load),
      .load_val  (ptr_load_val),
      .step_seq  (step_seq),
      .step_page (step_page),
      .ptr       (ptr)
   );

   i2c_mem_ctrl #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .DEV_CODE(DEV_CODE)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_lvl      (scl_lvl),
      .sda_lvl      (sda_lvl),
      .scl_rise     (scl_rise),
      .scl_fall     (scl_fall),
      .start_det    (start_det),
      .stop_det     (stop_det),
      .strap_sel    (strap_sel_i),
      .busy         (busy_i),
      .rd_data      (rd_data_i),
      .ptr          (ptr),
      .ptr_load     (ptr_load),
      .ptr_load_val (ptr_load_val),
      .step_seq     (step_seq),
      .step_page    (step_page),
      .sda_oe       (sda_oe_o),
      .wr_valid     (wr_valid_o),
      .wr_addr      (wr_addr_o),
      .wr_data      (wr_data_o),
      .wr_end       (wr_end_o)
   );

   assign rd_addr_o = ptr;

endmodule

// File: tb/i2c_mem_target_bench.sv
module i2c_mem_target_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic [2:0]  strap = 3'b101;
   logic        busy = 1'b0;
   logic        sda_oe;
   logic [12:0] rd_addr;
   logic [7:0]  rd_data;
   logic        wr_valid, wr_end;
   logic [12:0] wr_addr;
   logic [7:0]  wr_data;
   logic        sda_bus;

   int checks = 0;
   int errors = 0;
   int cap_n = 0;
   int end_n = 0;
   int viol = 0;
   bit done = 0;
   logic [12:0] cap_addr [0:63];
   logic [7:0]  cap_data [0:63];
   logic        oe_prev = 1'b0;
   logic        scl_prev_m = 1'b1;

   always #10 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   function automatic logic [7:0] mem_byte(input logic [12:0] a);
      return a[7:0] ^ {a[12:8], 3'b011};
   endfunction

   assign rd_data = mem_byte(rd_addr);

   i2c_mem_target u_i2c_mem_target (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl_m),
      .sda_i       (sda_bus),
      .sda_oe_o    (sda_oe),
      .strap_sel_i (strap),
      .busy_i      (busy),
      .rd_addr_o   (rd_addr),
      .rd_data_i   (rd_data),
      .wr_valid_o  (wr_valid),
      .wr_addr_o   (wr_addr),
      .wr_data_o   (wr_data),
      .wr_end_o    (wr_end)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_valid && cap_n < 64) begin
            cap_addr[cap_n] = wr_addr;
            cap_data[cap_n] = wr_data;
            cap_n++;
         end
         if (wr_end) end_n++;
         if (scl_m && scl_prev_m && (sda_oe != oe_prev)) viol++;
      end
      oe_prev    = sda_oe;
      scl_prev_m = scl_m;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(10);
      scl_m = 1'b1; tick(10);
      sda_m = 1'b0; tick(10);
      scl_m = 1'b0; tick(4);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(10);
      scl_m = 1'b1; tick(10);
      sda_m = 1'b1; tick(10);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(8);
         scl_m = 1'b1; tick(10);
         scl_m = 1'b0; tick(4);
      end
      sda_m = 1'b1; tick(8);
      scl_m = 1'b1; tick(5);
      acked = ~sda_bus;
      tick(5);
      scl_m = 1'b0; tick(4);
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(8);
         scl_m = 1'b1; tick(5);
         b[i] = sda_bus;
         tick(5);
         scl_m = 1'b0; tick(4);
      end
      sda_m = mack ? 1'b0 : 1'b1; tick(8);
      scl_m = 1'b1; tick(10);
      scl_m = 1'b0; tick(4);
      sda_m = 1'b1;
   endtask

   task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string req);
      bit a;
      bus_start();
      send_byte(8'hAA, a); check(a, "R2", {req, " write control ack"}, a, 1);
      send_byte(hi, a);    check(a, "R5", "address high ack", a, 1);
      send_byte(lo, a);    check(a, "R5", "address low ack", a, 1);
   endtask

   task automatic t_reset();
      check(sda_oe == 1'b0, "R1", "reset pull-down", sda_oe, 0);
      check(wr_valid == 1'b0 && wr_end == 1'b0, "R1", "reset strobes", {wr_valid, wr_end}, 0);
   endtask

   task automatic t_byte_write();
      bit a;
      int c0 = cap_n, e0 = end_n;
      set_addr(8'hE3, 8'h45, "byte write");
      send_byte(8'hA7, a); check(a, "R6", "data ack", a, 1);
      bus_stop(); tick(5);
      check(cap_n == c0 + 1, "R6", "write strobe count", cap_n - c0, 1);
      check(cap_addr[c0] == 13'h0345, "R5", "upper bits ignored addr", cap_addr[c0], 13'h0345);
      check(cap_data[c0] == 8'hA7, "R6", "write data", cap_data[c0], 8'hA7);
      check(end_n == e0 + 1, "R7", "commit at stop", end_n - e0, 1);
   endtask

   task automatic t_page_wrap();
      bit a;
      int c0 = cap_n;
      set_addr(8'h00, 8'h1E, "page");
      send_byte(8'h11, a);
      send_byte(8'h22, a);
      send_byte(8'h33, a); check(a, "R6", "third data ack", a, 1);
      bus_stop(); tick(5);
      check(cap_addr[c0] == 13'h001E, "R6", "page byte 0 addr", cap_addr[c0], 13'h001E);
      check(cap_addr[c0+1] == 13'h001F, "R6", "page byte 1 addr", cap_addr[c0+1], 13'h001F);
      check(cap_addr[c0+2] == 13'h0000 && cap_data[c0+2] == 8'h33, "R6", "page wrap addr",
            cap_addr[c0+2], 13'h0000);
   endtask

   task automatic t_current_read_nack(input logic [12:0] exp_a, input string req);
      bit a;
      logic [7:0] b;
      int e0 = end_n;
      bus_start();
      send_byte(8'hAB, a); check(a, "R2", "read control ack", a, 1);
      recv_byte(1'b0, b);
      check(b == mem_byte(exp_a), req, "current address read", b, mem_byte(exp_a));
      // R11: keep clocking with the line released; the target must stay off it
      for (int k = 0; k < 9; k++) begin
         tick(8); scl_m = 1'b1; tick(5);
         check(sda_bus == 1'b1, "R11", "line released after nack", sda_bus, 1);
         tick(5); scl_m = 1'b0; tick(4);
      end
      bus_stop(); tick(5);
      check(end_n == e0, "R7", "no commit after read", end_n - e0, 0);
   endtask

   task automatic t_random_seq(input logic [7:0] hi, input logic [7:0] lo,
                               input logic [12:0] a0, input logic [12:0] a1,
                               input logic [12:0] a2, input string req);
      bit a;
      logic [7:0] b;
      int c0 = cap_n, e0 = end_n;
      set_addr(hi, lo, "random");
      bus_start();
      send_byte(8'hAB, a); check(a, "R2", "read control after repeated start", a, 1);
      recv_byte(1'b1, b); check(b == mem_byte(a0), "R8", "first read byte", b, mem_byte(a0));
      recv_byte(1'b1, b); check(b == mem_byte(a1), req, "second read byte", b, mem_byte(a1));
      recv_byte(1'b0, b); check(b == mem_byte(a2), req, "third read byte", b, mem_byte(a2));
      bus_stop(); tick(5);
      check(cap_n == c0 && end_n == e0, "R7", "repeated start stores nothing",
            cap_n - c0 + end_n - e0, 0);
   endtask

   task automatic t_bad_code();
      bit a;
      int c0 = cap_n;
      bus_start();
      send_byte(8'hBA, a); check(!a, "R3", "wrong code nack", a, 0);
      send_byte(8'h00, a); check(!a, "R3", "ignored byte nack", a, 0);
      send_byte(8'h55, a); check(!a, "R3", "ignored byte nack", a, 0);
      bus_stop(); tick(5);
      check(cap_n == c0, "R3", "no strobe after mismatch", cap_n - c0, 0);
   endtask

   task automatic t_select();
      bit a;
      bus_start();
      send_byte(8'hA8, a); check(!a, "R3", "wrong select nack", a, 0);
      bus_stop();
      strap = 3'b100; tick(5);
      bus_start();
      send_byte(8'hA8, a); check(a, "R2", "select follows strap", a, 1);
      bus_stop();
      strap = 3'b101; tick(5);
   endtask

   task automatic t_busy();
      bit a;
      int e0 = end_n;
      busy = 1'b1;
      bus_start();
      send_byte(8'hAA, a); check(!a, "R4", "nack while busy", a, 0);
      bus_stop();
      busy = 1'b0; tick(5);
      bus_start();
      send_byte(8'hAA, a); check(a, "R4", "ack once idle", a, 1);
      bus_stop(); tick(5);
      check(end_n == e0, "R7", "stop without data stores nothing", end_n - e0, 0);
   endtask

   initial begin
      tick(5);
      t_reset();
      rst_n = 1'b1;
      tick(5);
      t_byte_write();
      t_page_wrap();
      t_current_read_nack(13'h0001, "R9");
      t_random_seq(8'h12, 8'h34, 13'h1234, 13'h1235, 13'h1236, "R10");
      t_current_read_nack(13'h1237, "R9");
      t_random_seq(8'hFF, 8'hFE, 13'h1FFE, 13'h1FFF, 13'h0000, "R10");
      t_bad_code();
      t_select();
      t_busy();
      check(viol == 0, "R8", "pull-down stable while clock high", viol, 0);
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule